// File: doc/BRIEF.md
# Interrupt Routing and Gating Unit

This block sits beside the trap logic of a processor core that has user, supervisor and machine privilege levels. In every cycle it looks at the current privilege level, the two global interrupt enables (one for machine level, one for supervisor level), one pending register and one enable register, and a delegation mask. From these it decides whether an interrupt is to be taken now, which level the trap goes to, and which cause number it carries. The delegation bit of a cause sets its destination, not the cause's name. A supervisor timer cause that is not delegated is a machine-level interrupt.

Only the machine pending and enable registers hold state. The supervisor pending and enable views are the machine registers ANDed with the delegation mask. Writes through a supervisor view reach only the delegated bits. A global enable gates only the interrupts aimed at the level the core is running at. Interrupts aimed at a higher level are always enabled. Interrupts aimed at a lower level are never taken.

The register port is CSR-like: a select code, a write strobe and write data, and a combinational read of the selected register. A separate status port loads the privilege level and both global enables.

Top module: `intr_gate`

## Requirements
- R1: A cause i goes to machine level when bit i of the delegation mask is 0 and to supervisor level when it is 1. `take_target` encodes user as 2'b00, supervisor as 2'b01 and machine as 2'b11.
- R2: A machine-level cause is taken when its pending and enable bits are both 1 and either the current level is below machine or the machine global enable is 1.
- R3: A supervisor-level cause is taken when its bits in the supervisor pending and enable views are both 1 and either the current level is user or the current level is supervisor with the supervisor global enable at 1.
- R4: While the current level is machine, no interrupt is routed to supervisor level, whatever the supervisor global enable says.
- R5: An interrupt aimed at a level above the current one ignores that level's global enable. Example: a non-delegated cause 5 is taken at supervisor level while the machine global enable is 0.
- R6: A read of the supervisor pending view (select 3) returns pending AND delegation. A read of the supervisor enable view (select 4) returns enable AND delegation. The machine pending register (select 0) keeps every pending bit visible.
- R7: A write through select 3 or 4 changes only the pending or enable bits whose delegation bit is 1. All other bits keep their value.
- R8: If any machine-level cause is takeable, it wins over every takeable supervisor-level cause.
- R9: Within one destination level, the fixed priority is 11, 9, 3, 1, 7, 5, from highest to lowest.
- R10: Only bits 1, 3, 5, 7, 9 and 11 exist in the pending, enable and delegation registers. All other bits read 0 and ignore writes.
- R11: After reset the level is machine, the pending, enable and delegation registers and both global enables are 0, and no interrupt is taken. The no-take output is cause 0 with target machine.
- R12: A status or register write takes effect at the next rising clock edge, and the take outputs follow the new state within that same cycle. A status write with the reserved level code 2'b10 leaves the level unchanged but still loads both global enables.
- R13: Select codes 0 to 4 pick machine pending, machine enable, delegation, supervisor pending view and supervisor enable view. Codes 5 to 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_wr_en | input | 1 | Load the privilege level and the global enables |
| st_level | input | 2 | New privilege level (00 user, 01 supervisor, 11 machine) |
| st_m_gie | input | 1 | New machine global enable |
| st_s_gie | input | 1 | New supervisor global enable |
| csr_wr_en | input | 1 | Register write strobe |
| csr_sel | input | 3 | Register select code |
| csr_wdata | input | IRQ_W | Register write data |
| csr_rdata | output | IRQ_W | Combinational read of the selected register |
| take_irq | output | 1 | An interrupt is to be taken in this cycle |
| take_target | output | 2 | Destination privilege level |
| take_cause | output | CAUSE_W | Selected cause number |

## Verification
The take outputs are combinational from the registered state. They are therefore due in the same cycle as the rising edge that captures a write. Read data is due as soon as the select changes. The bench drives every write on a falling edge and lets exactly one rising edge capture it. It updates its own model of the registers and checks take, target and cause on the following falling edge, one half period after the edge that changed the state. Reads are checked one time step after the select is set, with the write strobe low, so no check depends on the order of events at a clock edge.

// File: rtl/intr_pkg.sv
package intr_pkg;

  typedef enum logic [1:0] {
    LVL_USER  = 2'b00,
    LVL_SUPV  = 2'b01,
    LVL_RSVD  = 2'b10,
    LVL_MACH  = 2'b11
  } level_e;

  typedef enum logic [2:0] {
    SEL_M_PEND = 3'd0,
    SEL_M_EN   = 3'd1,
    SEL_DELEG  = 3'd2,
    SEL_S_PEND = 3'd3,
    SEL_S_EN   = 3'd4
  } csr_sel_e;

  localparam int unsigned NO_RANK = 15;

  // Causes that exist in this unit: software, timer and external at two levels.
  function automatic logic cause_exists(int unsigned idx);
    return (idx == 1) || (idx == 3) || (idx == 5) ||
           (idx == 7) || (idx == 9) || (idx == 11);
  endfunction

  // Lower rank wins: external, then software, then timer; higher bit first.
  function automatic int unsigned cause_rank(int unsigned idx);
    case (idx)
      11:      return 0;
      9:       return 1;
      3:       return 2;
      1:       return 3;
      7:       return 4;
      5:       return 5;
      default: return NO_RANK;
    endcase
  endfunction

  // Replace only the bits of old_v selected by mask with new_v.
  function automatic logic [63:0] merge_under(logic [63:0] old_v,
                                              logic [63:0] new_v,
                                              logic [63:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

endpackage

// File: rtl/intr_csr_file.sv
module intr_csr_file
  import intr_pkg::*;
#(
  parameter int unsigned IRQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       sel,
  input  logic [IRQ_W-1:0] wdata,
  output logic [IRQ_W-1:0] rdata,
  output logic [IRQ_W-1:0] pend_q,
  output logic [IRQ_W-1:0] en_q,
  output logic [IRQ_W-1:0] deleg_q
);

  logic [IRQ_W-1:0] exist_mask;

  genvar gi;
  generate
    for (gi = 0; gi < IRQ_W; gi++) begin : g_exist
      assign exist_mask[gi] = cause_exists(gi);
    end
  endgenerate

  logic [IRQ_W-1:0] wmask;
  assign wmask = wdata & exist_mask;

  logic [IRQ_W-1:0] pend_d, en_d, deleg_d;

  always_comb begin
    pend_d  = pend_q;
    en_d    = en_q;
    deleg_d = deleg_q;
    if (wr_en) begin
      case (sel)
        SEL_M_PEND: pend_d  = wmask;
        SEL_M_EN:   en_d    = wmask;
        SEL_DELEG:  deleg_d = wmask;
        SEL_S_PEND: pend_d  = IRQ_W'(merge_under(64'(pend_q), 64'(wmask), 64'(deleg_q)));
        SEL_S_EN:   en_d    = IRQ_W'(merge_under(64'(en_q), 64'(wmask), 64'(deleg_q)));
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      en_q    <= '0;
      deleg_q <= '0;
    end else begin
      pend_q  <= pend_d;
      en_q    <= en_d;
      deleg_q <= deleg_d;
    end
  end

  always_comb begin
    case (sel)
      SEL_M_PEND: rdata = pend_q;
      SEL_M_EN:   rdata = en_q;
      SEL_DELEG:  rdata = deleg_q;
      SEL_S_PEND: rdata = pend_q & deleg_q;
      SEL_S_EN:   rdata = en_q & deleg_q;
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/intr_status_reg.sv
module intr_status_reg
  import intr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] level_in,
  input  logic       m_gie_in,
  input  logic       s_gie_in,
  output logic [1:0] level_q,
  output logic       m_gie_q,
  output logic       s_gie_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LVL_MACH;
      m_gie_q <= 1'b0;
      s_gie_q <= 1'b0;
    end else if (wr_en) begin
      if (level_in != LVL_RSVD) level_q <= level_in;
      m_gie_q <= m_gie_in;
      s_gie_q <= s_gie_in;
    end
  end

endmodule

// File: rtl/intr_elig.sv
module intr_elig
  import intr_pkg::*;
#(
  parameter int unsigned IRQ_W = 16
) (
  input  logic [1:0]       level,
  input  logic             m_gie,
  input  logic             s_gie,
  input  logic [IRQ_W-1:0] pend,
  input  logic [IRQ_W-1:0] en,
  input  logic [IRQ_W-1:0] deleg,
  output logic             m_open,
  output logic             s_open,
  output logic [IRQ_W-1:0] m_cand,
  output logic [IRQ_W-1:0] s_cand
);

  logic [IRQ_W-1:0] s_pend_view, s_en_view;

  // Global gate: only interrupts aimed at the running level see its enable.
  assign m_open = (level != LVL_MACH) || m_gie;
  assign s_open = (level == LVL_USER) || ((level == LVL_SUPV) && s_gie);

  assign s_pend_view = pend & deleg;
  assign s_en_view   = en & deleg;

  assign m_cand = (pend & en & ~deleg) & {IRQ_W{m_open}};
  assign s_cand = (s_pend_view & s_en_view) & {IRQ_W{s_open}};

endmodule

// File: rtl/intr_prio_pick.sv
module intr_prio_pick
  import intr_pkg::*;
#(
  parameter int unsigned IRQ_W   = 16,
  parameter int unsigned CAUSE_W = $clog2(IRQ_W)
) (
  input  logic [IRQ_W-1:0]   vec,
  output logic               hit,
  output logic [CAUSE_W-1:0] cause
);

  int unsigned best_rank;

  always_comb begin
    best_rank = NO_RANK;
    cause     = '0;
    for (int unsigned i = 0; i < IRQ_W; i++) begin
      if (vec[i] && (cause_rank(i) < best_rank)) begin
        best_rank = cause_rank(i);
        cause     = CAUSE_W'(i);
      end
    end
  end

  assign hit = |vec;

endmodule

// File: rtl/intr_gate.sv
module intr_gate
  import intr_pkg::*;
#(
  parameter int unsigned IRQ_W   = 16,
  parameter int unsigned CAUSE_W = $clog2(IRQ_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_wr_en,
  input  logic [1:0]         st_level,
  input  logic               st_m_gie,
  input  logic               st_s_gie,
  input  logic               csr_wr_en,
  input  logic [2:0]         csr_sel,
  input  logic [IRQ_W-1:0]   csr_wdata,
  output logic [IRQ_W-1:0]   csr_rdata,
  output logic               take_irq,
  output logic [1:0]         take_target,
  output logic [CAUSE_W-1:0] take_cause
);

  logic [IRQ_W-1:0]   pend_q, en_q, deleg_q;
  logic [1:0]         level_q;
  logic               m_gie_q, s_gie_q;
  logic               m_open, s_open;
  logic [IRQ_W-1:0]   m_cand, s_cand;
  logic               m_hit, s_hit;
  logic [CAUSE_W-1:0] m_cause, s_cause;

  intr_csr_file #(.IRQ_W(IRQ_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(csr_wr_en), .sel(csr_sel),
    .wdata(csr_wdata), .rdata(csr_rdata),
    .pend_q(pend_q), .en_q(en_q), .deleg_q(deleg_q)
  );

  intr_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .wr_en(st_wr_en), .level_in(st_level),
    .m_gie_in(st_m_gie), .s_gie_in(st_s_gie),
    .level_q(level_q), .m_gie_q(m_gie_q), .s_gie_q(s_gie_q)
  );

  intr_elig #(.IRQ_W(IRQ_W)) u_elig (
    .level(level_q), .m_gie(m_gie_q), .s_gie(s_gie_q),
    .pend(pend_q), .en(en_q), .deleg(deleg_q),
    .m_open(m_open), .s_open(s_open), .m_cand(m_cand), .s_cand(s_cand)
  );

  intr_prio_pick #(.IRQ_W(IRQ_W), .CAUSE_W(CAUSE_W)) u_pick_m (
    .vec(m_cand), .hit(m_hit), .cause(m_cause)
  );

  intr_prio_pick #(.IRQ_W(IRQ_W), .CAUSE_W(CAUSE_W)) u_pick_s (
    .vec(s_cand), .hit(s_hit), .cause(s_cause)
  );

  // Machine-level candidates win over any supervisor-level candidate.
  always_comb begin
    take_irq    = m_hit || s_hit;
    take_target = LVL_MACH;
    take_cause  = '0;
    if (m_hit) begin
      take_cause = m_cause;
    end else if (s_hit) begin
      take_target = LVL_SUPV;
      take_cause  = s_cause;
    end
  end

endmodule

// File: rtl/intr_gate_chk.sv
module intr_gate_chk
  import intr_pkg::*;
#(
  parameter int unsigned IRQ_W   = 16,
  parameter int unsigned CAUSE_W = $clog2(IRQ_W)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               csr_wr_en,
  input logic [2:0]         csr_sel,
  input logic [IRQ_W-1:0]   csr_rdata,
  input logic               take_irq,
  input logic [1:0]         take_target,
  input logic [CAUSE_W-1:0] take_cause,
  input logic [IRQ_W-1:0]   pend_q,
  input logic [IRQ_W-1:0]   en_q,
  input logic [IRQ_W-1:0]   deleg_q,
  input logic [1:0]         level_q,
  input logic               m_gie_q
);

  // R1: the destination follows the delegation bit of the chosen cause.
  p_target_follows_deleg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (deleg_q[take_cause] == (take_target == LVL_SUPV)));

  // R2: a taken cause is both pending and enabled.
  p_taken_is_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (pend_q[take_cause] && en_q[take_cause]));

  // R4: no supervisor routing while running at machine level.
  p_no_supv_from_mach_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && (level_q == LVL_MACH)) |-> (take_target == LVL_MACH));

  // R5: at supervisor level, an armed non-delegated cause is always taken to machine level.
  p_higher_level_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((level_q == LVL_SUPV) && |(pend_q & en_q & ~deleg_q)) |-> (take_irq && take_target == LVL_MACH));

  // R6: the supervisor pending view is masked by delegation.
  p_supv_view_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_sel == SEL_S_PEND) |-> (csr_rdata == (pend_q & deleg_q)));

  // R7: a write through the supervisor pending view keeps non-delegated bits.
  p_supv_write_guarded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr_en && csr_sel == SEL_S_PEND) |=> ((pend_q & ~deleg_q) == $past(pend_q & ~deleg_q)));

  // R8: a supervisor routing only happens with no machine-level cause open.
  p_mach_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && take_target == LVL_SUPV) |->
      (((pend_q & en_q & ~deleg_q) == '0) || (level_q == LVL_MACH && !m_gie_q)));

endmodule

bind intr_gate intr_gate_chk #(.IRQ_W(IRQ_W), .CAUSE_W(CAUSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_sel(csr_sel),
  .csr_rdata(csr_rdata), .take_irq(take_irq), .take_target(take_target),
  .take_cause(take_cause), .pend_q(pend_q), .en_q(en_q), .deleg_q(deleg_q),
  .level_q(level_q), .m_gie_q(m_gie_q)
);

// File: tb/test_intr_gate.sv
module test_intr_gate;

  localparam int unsigned IRQ_W      = 16;
  localparam int unsigned CAUSE_W    = 4;
  localparam int          CLK_PERIOD = 10;
  localparam logic [IRQ_W-1:0] EXIST = 16'h0AAA;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               st_wr_en = 1'b0;
  logic [1:0]         st_level = 2'b11;
  logic               st_m_gie = 1'b0;
  logic               st_s_gie = 1'b0;
  logic               csr_wr_en = 1'b0;
  logic [2:0]         csr_sel = 3'd0;
  logic [IRQ_W-1:0]   csr_wdata = '0;
  logic [IRQ_W-1:0]   csr_rdata;
  logic               take_irq;
  logic [1:0]         take_target;
  logic [CAUSE_W-1:0] take_cause;

  int total = 0;
  int bad   = 0;

  // bench model
  logic [IRQ_W-1:0] mp = '0, me = '0, md = '0;
  logic [1:0]       mlvl = 2'b11;
  logic             mg = 1'b0, sg = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_gate #(.IRQ_W(IRQ_W), .CAUSE_W(CAUSE_W)) i_intr_gate (
    .clk(clk), .rst_n(rst_n), .st_wr_en(st_wr_en), .st_level(st_level),
    .st_m_gie(st_m_gie), .st_s_gie(st_s_gie), .csr_wr_en(csr_wr_en),
    .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .take_irq(take_irq), .take_target(take_target), .take_cause(take_cause)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // First hit in the listed order wins.
  function automatic logic [4:0] first_of(logic [IRQ_W-1:0] v);
    int order [6] = '{11, 9, 3, 1, 7, 5};
    foreach (order[k]) if (v[order[k]]) return {1'b1, 4'(order[k])};
    return 5'd0;
  endfunction

  // Returns {take, target, cause}
  function automatic logic [6:0] expect_take();
    logic [IRQ_W-1:0] mv, sv;
    logic [4:0] pm, ps;
    mv = (mlvl == 2'b11 && !mg) ? '0 : (mp & me & ~md);
    sv = ((mlvl == 2'b00) || (mlvl == 2'b01 && sg)) ? ((mp & md) & (me & md)) : '0;
    pm = first_of(mv);
    ps = first_of(sv);
    if (pm[4]) return {1'b1, 2'b11, pm[3:0]};
    if (ps[4]) return {1'b1, 2'b01, ps[3:0]};
    return {1'b0, 2'b11, 4'd0};
  endfunction

  function automatic logic [IRQ_W-1:0] expect_read(logic [2:0] s);
    case (s)
      3'd0: return mp;
      3'd1: return me;
      3'd2: return md;
      3'd3: return mp & md;
      3'd4: return me & md;
      default: return '0;
    endcase
  endfunction

  task automatic check_take(string req);
    logic [6:0] e;
    e = expect_take();
    check({req, " take"},   32'(take_irq),    32'(e[6]));
    check({req, " target"}, 32'(take_target), 32'(e[5:4]));
    check({req, " cause"},  32'(take_cause),  32'(e[3:0]));
  endtask

  task automatic read_chk(string req, logic [2:0] s);
    csr_wr_en = 1'b0;
    csr_sel   = s;
    #1;
    check({req, " rdata"}, 32'(csr_rdata), 32'(expect_read(s)));
  endtask

  task automatic csr_wr(logic [2:0] s, logic [IRQ_W-1:0] d);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_sel = s; csr_wdata = d;
    @(negedge clk);
    csr_wr_en = 1'b0;
    case (s)
      3'd0: mp = d & EXIST;
      3'd1: me = d & EXIST;
      3'd2: md = d & EXIST;
      3'd3: mp = (mp & ~md) | (d & EXIST & md);
      3'd4: me = (me & ~md) | (d & EXIST & md);
      default: ;
    endcase
  endtask

  task automatic st_wr(logic [1:0] l, logic m, logic s);
    @(negedge clk);
    st_wr_en = 1'b1; st_level = l; st_m_gie = m; st_s_gie = s;
    @(negedge clk);
    st_wr_en = 1'b0;
    if (l != 2'b10) mlvl = l;
    mg = m; sg = s;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check_take("R11");
    for (int s = 0; s < 5; s++) read_chk("R11", 3'(s));

    // R5: supervisor level, machine enable off, non-delegated cause 5 taken to machine
    csr_wr(3'd1, 16'h0020);
    csr_wr(3'd0, 16'h0020);
    st_wr(2'b01, 1'b0, 1'b0);
    check("R5 take", 32'(take_irq), 32'd1);
    check("R5 target", 32'(take_target), 32'h3);
    check("R5 cause", 32'(take_cause), 32'd5);

    // R6: cause 5 hidden in supervisor view until delegated
    read_chk("R6", 3'd3);
    check("R6 sview bit5", 32'(csr_rdata[5]), 32'd0);
    read_chk("R6", 3'd0);
    csr_wr(3'd2, 16'h0020);
    read_chk("R6", 3'd3);
    read_chk("R6", 3'd4);
    // R3: delegated, at supervisor with enable off: not taken; then enable on
    check_take("R3");
    st_wr(2'b01, 1'b0, 1'b1);
    check("R3 take", 32'(take_irq), 32'd1);
    check("R1 target", 32'(take_target), 32'h1);

    // R4: machine level, supervisor enable on, everything delegated
    st_wr(2'b11, 1'b1, 1'b1);
    check("R4 take", 32'(take_irq), 32'd0);

    // R7: supervisor write reaches only delegated bit 5
    csr_wr(3'd0, 16'h0000);
    csr_wr(3'd3, 16'hFFFF);
    read_chk("R7", 3'd0);
    check("R7 mpend", 32'(csr_rdata), 32'h0020);
    csr_wr(3'd4, 16'h0000);
    read_chk("R7", 3'd1);
    check("R7 men", 32'(csr_rdata), 32'h0000);

    // R10 / R13: absent bits and unused selects
    csr_wr(3'd0, 16'hFFFF);
    read_chk("R10", 3'd0);
    check("R10 mpend", 32'(csr_rdata), 32'h0AAA);
    csr_wr(3'd6, 16'h0000);
    read_chk("R13", 3'd6);
    read_chk("R13", 3'd0);

    // R9: priority within machine level
    csr_wr(3'd2, 16'h0000);
    csr_wr(3'd1, 16'hFFFF);
    st_wr(2'b00, 1'b0, 1'b0);
    check("R9 cause", 32'(take_cause), 32'd11);
    csr_wr(3'd1, 16'h00A0);
    check("R9 cause", 32'(take_cause), 32'd7);
    csr_wr(3'd1, 16'h002A);
    check("R9 cause", 32'(take_cause), 32'd3);

    // R8: delegated 11 pending vs machine-level 5: machine wins
    csr_wr(3'd2, 16'h0800);
    csr_wr(3'd1, 16'h0820);
    csr_wr(3'd0, 16'h0820);
    check("R8 target", 32'(take_target), 32'h3);
    check("R8 cause", 32'(take_cause), 32'd5);

    // R12: reserved level code ignored, enables still load
    st_wr(2'b10, 1'b1, 1'b0);
    check_take("R12");
    st_wr(2'b11, 1'b0, 1'b0);
    check("R2 take", 32'(take_irq), 32'd0);
    st_wr(2'b11, 1'b1, 1'b0);
    check("R2 take", 32'(take_irq), 32'd1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(3) == 0) begin
        st_wr(2'($urandom_range(3)), 1'($urandom_range(1)), 1'($urandom_range(1)));
      end else begin
        csr_wr(3'($urandom_range(5)), 16'($urandom()));
      end
      check_take("R1 R2 R3 R8 R9 random");
      read_chk("R6 R7 R13 random", 3'($urandom_range(7)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule